// File: doc/BRIEF.md
# Posted Write Buffer with Attribute Bypass

This block sits between a processor's write port and an external bus master port. Each write is either parked in a four-slot first-in-first-out queue or steered past the queue. The queue lets the processor go on while the bus is busy. The path taken depends on a buffer-enable control bit and on two attributes carried by each write: whether the target region is cache-inhibited, and whether the access is precise.

When the buffer is off, every write goes to the bus as its own transfer. When it is on, write-through writes and cache-inhibited imprecise writes are deferred into the queue. A cache-inhibited precise write always bypasses the queue. A bypassing write waits until all earlier queued writes have left, so writes reach the bus in the order the processor issued them.

The bus side is one registered output stage with a valid/ready handshake. An empty flag tells the processor when nothing is queued and no transfer is outstanding.

Top module: `store_post_buf`

## Requirements
- R1: After a synchronous reset, `buf_en` is 0, `bus_valid` is 0 and `empty` is 1.
- R2: With `buf_en` at 0, an accepted write is presented on the bus port at the first clock edge after acceptance. While the output stage is occupied and not being released, such a write is not accepted (`cpu_ready` is 0).
- R3: With `buf_en` at 1, a write with `cpu_cinh`=0, or with `cpu_cinh`=1 and `cpu_precise`=0, is deferred into the queue. On an idle bus it appears on the bus port at the second clock edge after acceptance, and `empty` is 0 after the first edge.
- R4: A write with `cpu_cinh`=1 and `cpu_precise`=1 bypasses the queue regardless of `buf_en`. On an idle bus it appears at the first edge after acceptance.
- R5: The queue holds at most DEPTH (default 4) deferred writes besides the output stage. A write that is to be deferred while the queue is full sees `cpu_ready`=0.
- R6: Writes appear on the bus port (address, data, byte enables) in exactly the order in which they were accepted, each exactly once.
- R7: A bypassing write is accepted only when the queue is empty and the output stage is free or being released in that cycle.
- R8: While `bus_valid` is 1 and `bus_ready` is 0, `bus_valid` stays 1 and the bus payload is unchanged at the next edge. An entry leaves only on a cycle with both high.
- R9: `empty` is 1 exactly when the queue holds no entries and `bus_valid` is 0.
- R10: A cycle with `cfg_we`=1 loads `cfg_en` into the enable bit, which is visible on `buf_en` after that edge and governs routing from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for the enable bit |
| cfg_en | input | 1 | New enable bit value |
| buf_en | output | 1 | Current enable bit |
| cpu_valid | input | 1 | Processor write request |
| cpu_ready | output | 1 | Write accepted this cycle when high with cpu_valid |
| cpu_addr | input | 32 | Write address |
| cpu_data | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables |
| cpu_cinh | input | 1 | 1 = cache-inhibited region, 0 = write-through region |
| cpu_precise | input | 1 | 1 = precise access, 0 = imprecise |
| bus_valid | output | 1 | Bus transfer pending |
| bus_ready | input | 1 | Bus accepts the transfer |
| bus_addr | output | 32 | Transfer address |
| bus_data | output | 32 | Transfer data |
| bus_be | output | 4 | Transfer byte enables |
| empty | output | 1 | No queued entries and no pending bus transfer |

## Verification
A bypassing write is due on the bus port one edge after it is accepted. A deferred write on an idle bus is due two edges after, because it passes through the queue before the output stage. `cpu_ready` is combinational and must be right in the same cycle as the request. `buf_en` and `empty` follow one edge after their cause. The bench drives inputs just after the falling edge and compares every output a moment later against a cycle model that it advances only at the rising edge. Each result is therefore judged in the cycle it is due and never one early or late. Directed runs pin these latencies down with explicit counts of edges.

// File: rtl/spb_pkg.sv
package spb_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
  } wr_t;
endpackage

// File: rtl/spb_route.sv
// Per-access routing decision: defer into the queue or bypass it.
module spb_route (
  input  logic en_i,
  input  logic cinh_i,
  input  logic precise_i,
  output logic defer_o
);
  logic force_bypass;
  always_comb begin
    force_bypass = cinh_i & precise_i;
    defer_o      = en_i & ~force_bypass;
  end
endmodule

// File: rtl/spb_fifo.sv
// Queue of pending writes; storage has no reset so it maps to RAM.
module spb_fifo #(
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  spb_pkg::wr_t  din_i,
  input  logic          pop_i,
  output spb_pkg::wr_t  head_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  spb_pkg::wr_t mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head_o  = mem[rd_ptr];
  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push_i |-> (cnt < CW'(DEPTH)));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> (cnt != '0));
endmodule

// File: rtl/spb_outreg.sv
// Single registered bus stage with valid/ready handshake.
module spb_outreg (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  spb_pkg::wr_t  din_i,
  input  logic          ready_i,
  output logic          valid_o,
  output spb_pkg::wr_t  dout_o,
  output logic          free_o
);
  assign free_o = ~valid_o | ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
    end else if (free_o) begin
      valid_o <= load_i;
    end
  end

  always_ff @(posedge clk) begin
    if (load_i && free_o) dout_o <= din_i;
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i) |=> (valid_o && $stable(dout_o)));

  // R7
  load_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |-> free_o);
endmodule

// File: rtl/store_post_buf.sv
module store_post_buf #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic        cfg_en,
  output logic        buf_en,
  input  logic        cpu_valid,
  output logic        cpu_ready,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_data,
  input  logic [3:0]  cpu_be,
  input  logic        cpu_cinh,
  input  logic        cpu_precise,
  output logic        bus_valid,
  input  logic        bus_ready,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_data,
  output logic [3:0]  bus_be,
  output logic        empty
);
  spb_pkg::wr_t cpu_ent, head, ob_din, ob_dout;
  logic en_q, defer, q_empty, q_full, ob_free;
  logic q_push, q_pop, byp_acc, ob_load;

  always_ff @(posedge clk) begin
    if (rst)         en_q <= 1'b0;
    else if (cfg_we) en_q <= cfg_en;
  end
  assign buf_en = en_q;

  spb_route route_i (
    .en_i(en_q), .cinh_i(cpu_cinh), .precise_i(cpu_precise), .defer_o(defer)
  );

  assign cpu_ent = '{addr: cpu_addr, data: cpu_data, be: cpu_be};

  always_comb begin
    cpu_ready = defer ? ~q_full : (q_empty & ob_free);
    q_push    = cpu_valid & cpu_ready & defer;
    byp_acc   = cpu_valid & cpu_ready & ~defer;
    q_pop     = ob_free & ~q_empty;
    ob_load   = q_pop | byp_acc;
    ob_din    = q_pop ? head : cpu_ent;
  end

  spb_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .push_i(q_push), .din_i(cpu_ent), .pop_i(q_pop),
    .head_o(head), .empty_o(q_empty), .full_o(q_full)
  );

  spb_outreg out_i (
    .clk(clk), .rst(rst), .load_i(ob_load), .din_i(ob_din),
    .ready_i(bus_ready), .valid_o(bus_valid), .dout_o(ob_dout), .free_o(ob_free)
  );

  assign bus_addr = ob_dout.addr;
  assign bus_data = ob_dout.data;
  assign bus_be   = ob_dout.be;
  assign empty    = q_empty & ~bus_valid;

  // R4
  precise_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready && cpu_cinh && cpu_precise) |-> !q_push);

  // R7
  bypass_order_chk: assert property (@(posedge clk) disable iff (rst)
    byp_acc |-> q_empty);

  // R9
  empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> !bus_valid);

  // R10
  en_load_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (buf_en == $past(cfg_en)));
endmodule

// File: tb/store_post_buf_tb_top.sv
module store_post_buf_tb_top;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0, cfg_en = 0, cpu_valid = 0, cpu_cinh = 0, cpu_precise = 0, bus_ready = 0;
  logic [31:0] cpu_addr = 0, cpu_data = 0;
  logic [3:0]  cpu_be = 0;
  logic buf_en, cpu_ready, bus_valid, empty;
  logic [31:0] bus_addr, bus_data;
  logic [3:0]  bus_be;

  always #5 clk = ~clk;

  store_post_buf #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_en(cfg_en), .buf_en(buf_en),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .cpu_be(cpu_be), .cpu_cinh(cpu_cinh),
    .cpu_precise(cpu_precise), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_be(bus_be), .empty(empty)
  );

  int checks = 0, errors = 0, cycles = 0;
  logic [67:0] exp_q[$];
  int  m_q = 0;
  bit  m_ob = 0, m_en = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic bit m_defer(input bit cinh, input bit prec);
    return m_en && !(cinh && prec);
  endfunction

  function automatic bit m_ready(input bit cinh, input bit prec);
    bit ob_free = !m_ob || bus_ready;
    if (m_defer(cinh, prec)) return m_q < DEPTH;
    return (m_q == 0) && ob_free;
  endfunction

  // One clock: drive at negedge, check, advance model at posedge.
  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be, input bit cinh, input bit prec,
                      input bit br, input bit cwe, input bit cen, output bit acc);
    bit er, dfr, ob_free, new_ob;
    cpu_valid = v; cpu_addr = a; cpu_data = d; cpu_be = be;
    cpu_cinh = cinh; cpu_precise = prec; bus_ready = br; cfg_we = cwe; cfg_en = cen;
    #1;
    er  = m_ready(cinh, prec);
    dfr = m_defer(cinh, prec);
    if (v) check(cpu_ready == er, dfr ? "R5 cpu_ready" : "R7 cpu_ready", cpu_ready, er);
    check(bus_valid == m_ob, "R8 bus_valid", bus_valid, m_ob);
    check(empty == (m_q == 0 && !m_ob), "R9 empty", empty, (m_q == 0 && !m_ob));
    check(buf_en == m_en, "R10 buf_en", buf_en, m_en);
    if (m_ob && bus_valid && exp_q.size() > 0)
      check({bus_addr, bus_data, bus_be} == exp_q[0], "R6 bus payload",
            {bus_addr, bus_data, bus_be}, exp_q[0]);
    acc = v && cpu_ready;
    @(posedge clk);
    ob_free = !m_ob || br;
    new_ob  = m_ob && !br;
    if (m_ob && br && exp_q.size() > 0) void'(exp_q.pop_front());
    if (ob_free && m_q > 0) begin m_q--; new_ob = 1; end
    else if (ob_free && v && er && !dfr) new_ob = 1;
    if (v && er && dfr) m_q++;
    if (v && er) exp_q.push_back({a, d, be});
    m_ob = new_ob;
    if (cwe) m_en = cen;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit br);
    bit acc;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, br, 0, 0, acc);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acc;
    int n;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    check(buf_en == 0, "R1 buf_en", buf_en, 0);
    check(bus_valid == 0, "R1 bus_valid", bus_valid, 0);
    check(empty == 1, "R1 empty", empty, 1);

    // R2 disabled: straight to bus next edge
    step(1, 32'h100, 32'hA1, 4'hF, 0, 0, 1, 0, 0, acc);
    check(acc && bus_valid == 1, "R2 bypass latency", bus_valid, 1);
    idle(2, 1);
    // R2 disabled with stalled bus: second write refused
    step(1, 32'h104, 32'hA2, 4'h3, 0, 0, 0, 0, 0, acc);
    step(1, 32'h108, 32'hA3, 4'hC, 0, 0, 0, 0, 0, acc);
    check(acc == 0, "R2 busy stage refuses", acc, 0);
    idle(3, 1);

    // R10 enable load
    step(0, 0, 0, 0, 0, 0, 1, 1, 1, acc);
    check(buf_en == 1, "R10 enable visible", buf_en, 1);

    // R3 deferred write-through, two edges to bus
    step(1, 32'h200, 32'hB1, 4'hF, 0, 0, 1, 0, 0, acc);
    check(bus_valid == 0 && empty == 0, "R3 first edge", {bus_valid, empty}, 2'b00);
    idle(1, 1);
    check(bus_valid == 1, "R3 second edge", bus_valid, 1);
    idle(2, 1);
    // R3 cache-inhibited imprecise also deferred
    step(1, 32'h204, 32'hB2, 4'h1, 1, 0, 1, 0, 0, acc);
    check(bus_valid == 0, "R3 cinh imprecise deferred", bus_valid, 0);
    idle(3, 1);

    // R4 cache-inhibited precise bypasses while enabled
    step(1, 32'h300, 32'hC1, 4'hF, 1, 1, 1, 0, 0, acc);
    check(bus_valid == 1, "R4 precise bypass", bus_valid, 1);
    idle(2, 1);

    // R5 fill with bus stalled: stage + DEPTH accepted
    n = 0;
    for (int i = 0; i < DEPTH + 3; i++) begin
      step(1, 32'h400 + i * 4, 32'hD0 + i, 4'hF, 0, 0, 0, 0, 0, acc);
      if (acc) n++;
    end
    check(n == DEPTH + 1, "R5 capacity", n, DEPTH + 1);
    // R7 bypass refused while queue holds entries
    step(1, 32'h500, 32'hE1, 4'hF, 1, 1, 0, 0, 0, acc);
    check(acc == 0, "R7 bypass waits", acc, 0);
    idle(10, 1);
    check(exp_q.size() == 0 && empty == 1, "R6 drained in order", exp_q.size(), 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit cwe = ($urandom % 40) == 0;
      step(($urandom % 4) != 0, $urandom, $urandom, 4'($urandom), 1'($urandom),
           1'($urandom), ($urandom % 3) != 0, cwe, 1'($urandom), acc);
    end
    idle(DEPTH + 6, 1);
    check(exp_q.size() == 0, "R6 all delivered", exp_q.size(), 0);
    check(empty == 1, "R9 final empty", empty, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule